// File: doc/BRIEF.md
# Periodic Down-Counter Tick Timer

This block is a 24-bit down-counter. It produces a regular time base and an optional interrupt pulse. Software sets it up through four word-aligned 32-bit registers on a simple valid/write/address/data port: control/status, reload value, current value and a read-only calibration constant. Once enabled, the counter takes one step down on every enabled tick. A tick is either every core clock cycle or each cycle in which an external reference strobe is high. The control register picks between the two.

When the counter is at zero and a tick arrives, the block wraps. It sets a sticky flag that software can observe, and it emits a one-cycle interrupt pulse if the interrupt enable is set. It then restarts from the reload value, so a reload value of N gives a period of N+1 ticks. If the reload value is zero at that moment, the block clears its own enable and stops. Reading the control/status register returns the flag and then clears it. Any write to the current-value register restarts the count and clears the flag.

Top module: `tick_timer`

## Requirements
- R1: Synchronous active-low reset clears control, reload, counter and flag. After reset, the control, reload and current registers read 0 and `irq` is low.
- R2: A write to the control/status register (offset 0x0) updates only bits [2:0]: bit 0 enable, bit 1 interrupt enable, bit 2 source select. Bit 16 and all other bits read back as 0 unless set by the block.
- R3: A write that takes the enable bit from 0 to 1 loads the counter with the reload value (offset 0x4). Each tick after that lowers the counter by one, and wraps repeat every N+1 ticks for a reload value N.
- R4: With source select 1, every clock cycle is a tick. With source select 0, only cycles with `ext_tick` high are ticks.
- R5: A tick while the counter is at zero sets the flag in bit 16 of control/status and reloads the counter with the reload value.
- R6: On a wrap with interrupt enable set, `irq` is high for exactly the one cycle after the wrapping clock edge. With interrupt enable clear, `irq` stays low.
- R7: A read of control/status returns the flag and clears it at the next edge. If a wrap falls in the same cycle as that read, the read returns the old value and the flag ends up set.
- R8: Any write to the current-value register (offset 0x8), whatever the data, loads the counter with the reload value and clears the flag. No tick is applied in that cycle.
- R9: If the reload value is zero when a wrap occurs, the enable bit clears and counting stops.
- R10: The current-value register reads 0 while the enable bit is clear. Bits [31:24] of the reload and current registers always read 0 and are not stored.
- R11: The calibration register at offset 0xC is read-only and reads the constant 10000.
- R12: Accesses to unmapped offsets, and accesses with `bus_word` low, change no state, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access; other sizes are ignored |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the same cycle as a read request, otherwise 0 |
| ext_tick | input | 1 | Single-cycle reference strobe, synchronous to `clk` |
| irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
Two things can happen in the same cycle: the flag is set by a wrap, and it is cleared by a control/status read. The bench lets the counter run down to zero under the core clock and places the read in exactly the cycle whose closing edge performs the wrap. That read must return the flag as clear. A second read must then show the flag set, which shows that the set from the wrap takes priority over the clear from the read. A related pairing is a write to the current-value register against a pending tick. It is judged by the counter holding the reload value on the next read rather than one less.

// File: rtl/tick_timer_pkg.sv
// Package: shared offsets, bit positions and constants of the tick timer.
// Assumes byte offsets fit in 8 bits; the top truncates them to ADDR_W.
package tick_timer_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RLD   = 8'h04;
    localparam logic [7:0] OFS_CUR   = 8'h08;
    localparam logic [7:0] OFS_CALIB = 8'h0C;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_INT_BIT = 1;
    localparam int CTL_SRC_BIT = 2;
    localparam int CTL_W       = 3;
    localparam int FLAG_BIT    = 16;

    localparam logic [31:0] CALIB_VALUE = 32'd10000;
endpackage

// File: rtl/tick_timer_gate.sv
// Tick gate: decides whether the counter steps this cycle.
// Assumes ext_tick is already synchronous to clk. A bus write to control or
// current value takes priority, so no step happens in that cycle.
module tick_timer_gate (
    input  logic enable,
    input  logic src_core,
    input  logic ext_tick,
    input  logic bus_hold,
    output logic step
);
    // Select the tick source, then qualify it with enable and the bus hold.
    always_comb begin
        step = enable && (src_core || ext_tick) && !bus_hold;
    end
endmodule

// File: rtl/tick_timer_regs.sv
// Register bank: control bits, reload value and the sticky wrap flag.
// Assumes at most one bus access per cycle and that wrap is never high in a
// cycle with a control or current-value write (the gate blocks that step).
module tick_timer_regs #(
    parameter int CNT_W = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_ctl,
    input  logic                           wr_rld,
    input  logic                           wr_cur,
    input  logic                           rd_ctl,
    input  logic [tick_timer_pkg::CTL_W-1:0] wdata_ctl,
    input  logic [CNT_W-1:0]               wdata_rld,
    input  logic                           wrap,
    output logic [tick_timer_pkg::CTL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]               reload_q,
    output logic                           flag_q,
    output logic                           load
);
    import tick_timer_pkg::*;

    // Counter load request: restart on a current-value write or an enable rise.
    always_comb begin
        load = wr_cur || (wr_ctl && wdata_ctl[CTL_EN_BIT] && !ctrl_q[CTL_EN_BIT]);
    end

    // Control bits: bus write wins; a wrap with zero reload drops the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctl) begin
            ctrl_q <= wdata_ctl;
        end else if (wrap && (reload_q == '0)) begin
            ctrl_q[CTL_EN_BIT] <= 1'b0;
        end
    end

    // Reload value: plain storage of the low CNT_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_rld) begin
            reload_q <= wdata_rld;
        end
    end

    // Sticky flag: current write clears, a wrap sets over a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_cur) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (rd_ctl) begin
            flag_q <= 1'b0;
        end
    end

    assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);

    assert_zero_reload_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && reload_q == '0) |=> !ctrl_q[CTL_EN_BIT]);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && !wrap) |=> !flag_q);
endmodule

// File: rtl/tick_timer_counter.sv
// Down-counter with wrap detection and a registered one-cycle interrupt.
// Assumes load and step are never both high (the gate blocks step on writes).
module tick_timer_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    input  logic             int_en,
    output logic [CNT_W-1:0] count_q,
    output logic             wrap,
    output logic             irq_q
);
    // Wrap event: a tick arriving while the count already sits at zero.
    always_comb begin
        wrap = step && (count_q == '0);
    end

    // Count register: load, or step down, or restart from reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= reload;
        end else if (step) begin
            count_q <= wrap ? reload : count_q - 1'b1;
        end
    end

    // Interrupt pulse: high for one cycle after an enabled wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap && int_en;
        end
    end

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(reload)));

    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count_q));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
endmodule

// File: rtl/tick_timer.sv
// Top of the tick timer: bus decode, read mux and the three sub-blocks.
// Assumes a single-cycle access port; read data is combinational in the
// request cycle, and read side effects take place at the closing edge.
module tick_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    import tick_timer_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RLD   = ADDR_W'(OFS_RLD);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(OFS_CUR);
    localparam logic [ADDR_W-1:0] A_CALIB = ADDR_W'(OFS_CALIB);

    logic               acc_ok, wr_ok, rd_ok;
    logic               wr_ctl, wr_rld, wr_cur, rd_ctl;
    logic [CTL_W-1:0]   ctrl_q;
    logic [CNT_W-1:0]   reload_q, count_q;
    logic               flag_q, load, step, wrap;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    // Access decode: only full-word requests count as accesses.
    always_comb begin
        acc_ok = bus_valid && bus_word;
        wr_ok  = acc_ok && bus_write;
        rd_ok  = acc_ok && !bus_write;
        wr_ctl = wr_ok && (bus_addr == A_CTRL);
        wr_rld = wr_ok && (bus_addr == A_RLD);
        wr_cur = wr_ok && (bus_addr == A_CUR);
        rd_ctl = rd_ok && (bus_addr == A_CTRL);
    end

    tick_timer_gate u_gate (
        .enable   (ctrl_q[CTL_EN_BIT]),
        .src_core (ctrl_q[CTL_SRC_BIT]),
        .ext_tick (ext_tick),
        .bus_hold (wr_ctl || wr_cur),
        .step     (step)
    );

    tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .wr_rld    (wr_rld),
        .wr_cur    (wr_cur),
        .rd_ctl    (rd_ctl),
        .wdata_ctl (bus_wdata[CTL_W-1:0]),
        .wdata_rld (bus_wdata[CNT_W-1:0]),
        .wrap      (wrap),
        .ctrl_q    (ctrl_q),
        .reload_q  (reload_q),
        .flag_q    (flag_q),
        .load      (load)
    );

    tick_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .reload  (reload_q),
        .int_en  (ctrl_q[CTL_INT_BIT]),
        .count_q (count_q),
        .wrap    (wrap),
        .irq_q   (irq)
    );

    // Read mux: zero outside mapped full-word reads; current is zero when off.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (bus_addr)
                A_CTRL: begin
                    bus_rdata[CTL_W-1:0] = ctrl_q;
                    bus_rdata[FLAG_BIT]  = flag_q;
                end
                A_RLD:   bus_rdata = DATA_W'(reload_q);
                A_CUR:   bus_rdata = ctrl_q[CTL_EN_BIT] ? DATA_W'(count_q) : '0;
                A_CALIB: bus_rdata = DATA_W'(CALIB_VALUE);
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    assert_cur_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> (!flag_q && !irq));
endmodule

// File: tb/tick_timer_tb.sv
// Bench for tick_timer: a vector table walked by one loop, then directed
// scenarios for reset, counting, wrap, interrupt and concurrency corners.
module tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_word = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_tick(ext_tick), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Table: external source with no strobes, so the counter holds still.
    localparam vec_t VECS [0:14] = '{
        '{1'b1, 8'h04, 32'hFF00_0123, 32'h0, 4'd10},  // R10 upper bits dropped
        '{1'b0, 8'h04, 32'h0, 32'h0000_0123, 4'd10},
        '{1'b1, 8'h00, 32'hFFFF_FFF1, 32'h0, 4'd2},   // R2 only [2:0] kept
        '{1'b0, 8'h00, 32'h0, 32'h0000_0001, 4'd2},
        '{1'b0, 8'h08, 32'h0, 32'h0000_0123, 4'd3},   // R3 load on enable
        '{1'b0, 8'h0C, 32'h0, 32'd10000, 4'd11},      // R11 calibration
        '{1'b1, 8'h10, 32'h0000_0005, 32'h0, 4'd12},  // R12 unmapped write
        '{1'b0, 8'h10, 32'h0, 32'h0, 4'd12},
        '{1'b0, 8'h00, 32'h0, 32'h0000_0001, 4'd12},
        '{1'b1, 8'h00, 32'h0, 32'h0, 4'd2},
        '{1'b0, 8'h08, 32'h0, 32'h0, 4'd10},          // R10 disabled reads 0
        '{1'b1, 8'h00, 32'h0000_0006, 32'h0, 4'd2},
        '{1'b0, 8'h00, 32'h0, 32'h0000_0006, 4'd2},
        '{1'b0, 8'h08, 32'h0, 32'h0, 4'd10},
        '{1'b1, 8'h00, 32'h0, 32'h0, 4'd2}
    };

    // Record one check and print a FAIL line on mismatch.
    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        bus_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        bus_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic w = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_word = 1'b1;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, input logic w = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b0; bus_word = w; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_word = 1'b1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input int req,
                          input string what, input logic w = 1'b1);
        logic [31:0] d;
        bus_rd(a, d, w);
        chk(req, d, exp, what);
    endtask

    task automatic ext_pulse();
        ext_tick = 1'b1;
        @(posedge clk); #1;
        ext_tick = 1'b0;
    endtask

    task automatic wait_irq(output int t);
        t = -1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (irq) begin
                t = cyc;
                break;
            end
        end
    endtask

    initial begin
        logic [31:0] d;
        int t1, t2;
        do_reset();

        // Vector table walk.
        for (int i = 0; i < 15; i++) begin
            if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
            else rd_chk(VECS[i].addr, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R1: reset state.
        do_reset();
        chk(1, {31'b0, irq}, 32'h0, "irq after reset");
        rd_chk(8'h00, 32'h0, 1, "ctrl after reset");
        rd_chk(8'h04, 32'h0, 1, "reload after reset");
        rd_chk(8'h08, 32'h0, 1, "current after reset");

        // R3 R4: core clock counts every cycle from the reload value.
        bus_wr(8'h04, 32'd3);
        bus_wr(8'h00, 32'h7);
        rd_chk(8'h08, 32'd3, 3, "count after enable");
        rd_chk(8'h08, 32'd2, 4, "core tick 1");
        rd_chk(8'h08, 32'd1, 4, "core tick 2");
        rd_chk(8'h08, 32'd0, 4, "core tick 3");
        chk(6, {31'b0, irq}, 32'h1, "irq after wrap");               // R6
        rd_chk(8'h00, 32'h0001_0007, 5, "flag set on wrap");          // R5
        chk(6, {31'b0, irq}, 32'h0, "irq lasts one cycle");          // R6
        rd_chk(8'h00, 32'h0000_0007, 7, "flag cleared by read");      // R7
        wait_irq(t1);
        wait_irq(t2);
        chk(3, t2 - t1, 32'd4, "period for reload 3");               // R3

        // R4: external strobe source, interrupt disabled.
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'd5);
        bus_rd(8'h00, d);
        bus_wr(8'h00, 32'h1);
        idle(3);
        rd_chk(8'h08, 32'd5, 4, "no strobe no count");
        ext_pulse(); idle(1);
        ext_pulse(); idle(1);
        rd_chk(8'h08, 32'd3, 4, "two strobes");
        ext_pulse(); ext_pulse(); ext_pulse(); ext_pulse();
        chk(6, {31'b0, irq}, 32'h0, "no irq when disabled");         // R6
        rd_chk(8'h00, 32'h0001_0001, 5, "flag on strobe wrap");       // R5
        rd_chk(8'h08, 32'd5, 5, "reloaded after wrap");

        // R8: write to current restarts and clears the flag.
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'd2);
        bus_wr(8'h00, 32'h5);
        idle(5);
        bus_wr(8'h08, 32'hDEAD_BEEF);
        rd_chk(8'h08, 32'd2, 8, "current write restarts");
        rd_chk(8'h00, 32'h0000_0005, 8, "current write clears flag");

        // R7: read of control in the same cycle as a wrap.
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, d);
        bus_wr(8'h00, 32'h5);
        idle(2);
        rd_chk(8'h00, 32'h0000_0005, 7, "read during wrap sees old flag");
        rd_chk(8'h00, 32'h0001_0005, 7, "wrap set beats read clear");

        // R9: zero reload stops the timer at expiry.
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h00, d);
        bus_wr(8'h00, 32'h5);
        idle(1);
        rd_chk(8'h00, 32'h0001_0004, 9, "enable cleared at zero reload");
        rd_chk(8'h08, 32'h0, 10, "current zero once stopped");
        idle(3);
        rd_chk(8'h00, 32'h0000_0004, 9, "stays stopped");

        // R12: non-word accesses are ignored.
        bus_wr(8'h04, 32'h77, 1'b0);
        rd_chk(8'h04, 32'h0, 12, "partial write ignored");
        rd_chk(8'h0C, 32'h0, 12, "partial read returns 0", 1'b0);
        bus_wr(8'h00, 32'h1, 1'b0);
        rd_chk(8'h00, 32'h0000_0004, 12, "partial ctrl write ignored");

        // R1: reset in the middle of a run.
        bus_wr(8'h04, 32'd9);
        bus_wr(8'h00, 32'h7);
        idle(3);
        do_reset();
        chk(1, {31'b0, irq}, 32'h0, "irq after mid-run reset");
        rd_chk(8'h00, 32'h0, 1, "ctrl after mid-run reset");
        rd_chk(8'h04, 32'h0, 1, "reload after mid-run reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule